// File: doc/BRIEF.md
# Release-to-Test Rotation Scheduler

This block steps a release-to-test sweep across a grid of `ROWS` by `COLS` logic cells. For the cell it currently points at, it first raises a replicate request and holds it until the replicate-done strobe arrives. It then raises a test request and holds it until the test-done strobe arrives. After that it moves to the next cell. The reconfiguration and the test themselves happen outside the block. To the scheduler they are only request/done pairs of plain control pins, and there is no data stream at its edge.

The walk order follows a primary axis chosen by a parameter. With the vertical axis, cells that share a column are visited back to back, so cells joined by a carry chain stay next to each other; the horizontal axis is the alternative. At each end of the grid the walk turns round instead of wrapping. Because of this, the time before a cell is visited again swings between a short bound and a long bound.

A fault flag given together with test-done stops the rotation and keeps the coordinates of the failing cell. A synchronous reset starts the walk again at cell (0,0) in the forward direction.

Top module: `rtt_rotation_sched`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it is released, the outputs read as follows: `cur_row`=0, `cur_col`=0, `dir_back`=0 (forward), `step_cnt`=0, `pass_done`=0, `fault_hit`=0, `rep_req`=1 and `test_req`=0.
- R2: `rep_req` stays high until `rep_done` is seen high at a clock edge. `test_req` is high from the next cycle and stays high until `test_done` is seen high at an edge. The two requests are never high together. A done strobe that arrives while its own request is low is ignored.
- R3: Cells are ordered by a linear index k running from 0 to ROWS·COLS−1. With `VERT_AXIS`=1, k = col·ROWS + row, so the row changes fastest. With `VERT_AXIS`=0, k = row·COLS + col.
- R4: A forward pass moves in increasing k and ends at k = ROWS·COLS−1. A backward pass moves in decreasing k and ends at k = 0. When an end cell's test completes without a fault, `dir_back` inverts (0 = forward, 1 = backward), `pass_done` is high for exactly the next cycle, and the next cell is the neighbour of the end cell in the new direction. The end cell is not visited twice in a row.
- R5: `step_cnt` goes up by one on every accepted `test_done`, including the one that carries a fault. It wraps modulo 2^STEP_W.
- R6: The block waits in a phase for as long as the done strobe takes, with no deadline. While it waits, `cur_row` and `cur_col` do not change.
- R7: `fault_in` is sampled only together with an accepted `test_done`. When it is set, `fault_hit` goes high on the next cycle and `fault_row` and `fault_col` hold the tested cell. Both requests then stay low, the coordinates stay frozen, and any later done strobe has no effect until reset.
- R8: Let each replicate phase last Tr cycles and each test phase last Tt cycles, and let N = ROWS·COLS. A step then takes Tr+Tt cycles. Cell k=0 is revisited every 2·(N−1)·(Tr+Tt) cycles, which is the maximum bound. Cell k=1 alternates between 2·(Tr+Tt), the minimum bound, and 2·(N−2)·(Tr+Tt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rep_done | input | 1 | Replicate finished strobe |
| test_done | input | 1 | Test finished strobe |
| fault_in | input | 1 | Test result is faulty, qualified by test_done |
| rep_req | output | 1 | Replicate request for the current cell |
| test_req | output | 1 | Test request for the current cell |
| cur_row | output | RW | Row of the current cell |
| cur_col | output | CW | Column of the current cell |
| dir_back | output | 1 | Walk direction, 1 = backward |
| pass_done | output | 1 | One-cycle pulse at the end of a pass |
| step_cnt | output | STEP_W | Number of completed steps |
| fault_hit | output | 1 | Rotation halted on a fault |
| fault_row | output | RW | Row of the failing cell |
| fault_col | output | CW | Column of the failing cell |

## Verification
The bench goes after the turnaround cells, where a design that repeats the end cell or wraps to the far corner would show a wrong next coordinate, a missing `pass_done` pulse or an unchanged direction. It injects stray done strobes and stray fault flags during the opposite phase. A design that honours them would jump ahead a cell, skip the test phase or halt early. With fixed phase lengths it times the revisits of cell 0 and cell 1 against the two bounds; a design with an idle cycle between steps, or with the wrong turnaround, misses them by a fixed amount. Finally it checks that a halted design ignores every later strobe and that reset brings the walk back to the origin going forward.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    PH_REP  = 2'd0,
    PH_TST  = 2'd1,
    PH_HALT = 2'd2
  } phase_t;
endpackage

// File: rtl/rtt_walker.sv
module rtt_walker #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int IW    = 2,
  parameter int OW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] in_q,
  output logic [OW-1:0] out_q,
  output logic          back_q,
  output logic          wrap_q
);
  localparam int TOTAL = N_IN * N_OUT;
  localparam logic [IW-1:0] IN_MAX  = IW'(N_IN - 1);
  localparam logic [OW-1:0] OUT_MAX = OW'(N_OUT - 1);

  logic at_fwd_end, at_bwd_end, at_end, go_back;
  logic [IW-1:0] in_n;
  logic [OW-1:0] out_n;

  assign at_fwd_end = (in_q == IN_MAX) && (out_q == OUT_MAX);
  assign at_bwd_end = (in_q == '0) && (out_q == '0);
  assign at_end     = back_q ? at_bwd_end : at_fwd_end;
  assign go_back    = at_end ? ~back_q : back_q;

  always_comb begin
    in_n  = in_q;
    out_n = out_q;
    if (TOTAL > 1) begin
      if (!go_back) begin
        if (in_q == IN_MAX) begin
          in_n  = '0;
          out_n = out_q + OW'(1);
        end else begin
          in_n  = in_q + IW'(1);
        end
      end else begin
        if (in_q == '0) begin
          in_n  = IN_MAX;
          out_n = out_q - OW'(1);
        end else begin
          in_n  = in_q - IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= '0;
      out_q  <= '0;
      back_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= adv && at_end && (TOTAL > 1);
      if (adv) begin
        in_q   <= in_n;
        out_q  <= out_n;
        back_q <= (TOTAL > 1) ? go_back : 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtt_phase_ctl.sv
module rtt_phase_ctl
  import rtt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rep_done,
  input  logic test_done,
  input  logic fault_in,
  output logic rep_req,
  output logic test_req,
  output logic fin,
  output logic adv,
  output logic trap
);
  phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_REP;
    end else begin
      case (ph)
        PH_REP:  if (rep_done) ph <= PH_TST;
        PH_TST:  if (test_done) ph <= fault_in ? PH_HALT : PH_REP;
        default: ph <= PH_HALT;
      endcase
    end
  end

  assign rep_req  = (ph == PH_REP);
  assign test_req = (ph == PH_TST);
  assign fin      = test_req && test_done;
  assign adv      = fin && !fault_in;
  assign trap     = fin && fault_in;
endmodule

// File: rtl/rtt_track.sv
module rtt_track #(
  parameter int RW = 2,
  parameter int CW = 2,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fin,
  input  logic          trap,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  output logic [SW-1:0] step_cnt,
  output logic          fault_hit,
  output logic [RW-1:0] fault_row,
  output logic [CW-1:0] fault_col
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step_cnt  <= '0;
      fault_hit <= 1'b0;
      fault_row <= '0;
      fault_col <= '0;
    end else begin
      if (fin) step_cnt <= step_cnt + SW'(1);
      if (trap) begin
        fault_hit <= 1'b1;
        fault_row <= row;
        fault_col <= col;
      end
    end
  end
endmodule

// File: rtl/rtt_rotation_sched.sv
module rtt_rotation_sched #(
  parameter int ROWS      = 4,
  parameter int COLS      = 3,
  parameter bit VERT_AXIS = 1'b1,
  parameter int STEP_W    = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rep_done,
  input  logic              test_done,
  input  logic              fault_in,
  output logic              rep_req,
  output logic              test_req,
  output logic [RW-1:0]     cur_row,
  output logic [CW-1:0]     cur_col,
  output logic              dir_back,
  output logic              pass_done,
  output logic [STEP_W-1:0] step_cnt,
  output logic              fault_hit,
  output logic [RW-1:0]     fault_row,
  output logic [CW-1:0]     fault_col
);
  logic fin, adv, trap;

  rtt_phase_ctl u_phase (
    .clk(clk), .rst(rst), .rep_done(rep_done), .test_done(test_done),
    .fault_in(fault_in), .rep_req(rep_req), .test_req(test_req),
    .fin(fin), .adv(adv), .trap(trap)
  );

  generate
    if (VERT_AXIS) begin : g_vert
      rtt_walker #(.N_IN(ROWS), .N_OUT(COLS), .IW(RW), .OW(CW)) u_walk (
        .clk(clk), .rst(rst), .adv(adv), .in_q(cur_row), .out_q(cur_col),
        .back_q(dir_back), .wrap_q(pass_done)
      );
    end else begin : g_horz
      rtt_walker #(.N_IN(COLS), .N_OUT(ROWS), .IW(CW), .OW(RW)) u_walk (
        .clk(clk), .rst(rst), .adv(adv), .in_q(cur_col), .out_q(cur_row),
        .back_q(dir_back), .wrap_q(pass_done)
      );
    end
  endgenerate

  rtt_track #(.RW(RW), .CW(CW), .SW(STEP_W)) u_track (
    .clk(clk), .rst(rst), .fin(fin), .trap(trap), .row(cur_row), .col(cur_col),
    .step_cnt(step_cnt), .fault_hit(fault_hit), .fault_row(fault_row),
    .fault_col(fault_col)
  );
endmodule

// File: rtl/rtt_rotation_sched_chk.sv
module rtt_rotation_sched_chk #(
  parameter int RW = 2,
  parameter int CW = 2,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rep_done,
  input logic          test_done,
  input logic          rep_req,
  input logic          test_req,
  input logic [RW-1:0] cur_row,
  input logic [CW-1:0] cur_col,
  input logic          dir_back,
  input logic          pass_done,
  input logic [SW-1:0] step_cnt,
  input logic          fault_hit,
  input logic [RW-1:0] fault_row,
  input logic [CW-1:0] fault_col
);
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rep_req && test_req)); // R2
  AST_REP_TO_TEST: assert property (@(posedge clk) disable iff (rst)
    (rep_req && rep_done) |=> (test_req && !rep_req)); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((rep_req && !rep_done) || (test_req && !test_done)) |=>
      ($stable(cur_row) && $stable(cur_col))); // R6
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (test_req && test_done) |=> (step_cnt == $past(step_cnt) + SW'(1))); // R5
  AST_PASS_FLIP: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> (dir_back != $past(dir_back))); // R4
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    fault_hit |-> (!rep_req && !test_req)); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_hit |=> (fault_hit && $stable(fault_row) && $stable(fault_col) &&
                   $stable(step_cnt) && $stable(cur_row) && $stable(cur_col))); // R7
endmodule

bind rtt_rotation_sched rtt_rotation_sched_chk #(.RW(RW), .CW(CW), .SW(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .rep_done(rep_done), .test_done(test_done),
  .rep_req(rep_req), .test_req(test_req), .cur_row(cur_row), .cur_col(cur_col),
  .dir_back(dir_back), .pass_done(pass_done), .step_cnt(step_cnt),
  .fault_hit(fault_hit), .fault_row(fault_row), .fault_col(fault_col)
);

// File: tb/rtt_rotation_sched_bench.sv
module rtt_rotation_sched_bench;
  localparam int ROWS = 4;
  localparam int COLS = 3;
  localparam int N    = ROWS * COLS;
  localparam int RW   = 2;
  localparam int CW   = 2;
  localparam int SW   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rep_done = 1'b0, test_done = 1'b0, fault_in = 1'b0;
  logic rep_req, test_req, dir_back, pass_done, fault_hit;
  logic [RW-1:0] cur_row, fault_row;
  logic [CW-1:0] cur_col, fault_col;
  logic [SW-1:0] step_cnt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int e_idx, e_step;
  bit e_back;
  int last_visit [N];
  int step_start;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtt_rotation_sched #(.ROWS(ROWS), .COLS(COLS), .VERT_AXIS(1'b1), .STEP_W(SW))
  u_rtt_rotation_sched (
    .clk(clk), .rst(rst), .rep_done(rep_done), .test_done(test_done),
    .fault_in(fault_in), .rep_req(rep_req), .test_req(test_req),
    .cur_row(cur_row), .cur_col(cur_col), .dir_back(dir_back),
    .pass_done(pass_done), .step_cnt(step_cnt), .fault_hit(fault_hit),
    .fault_row(fault_row), .fault_col(fault_col)
  );

  function automatic int row_of(int k); return k % ROWS; endfunction
  function automatic int col_of(int k); return k / ROWS; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_pos(string tag);
    chk(int'(cur_row) == row_of(e_idx), {tag, " row"}, int'(cur_row), row_of(e_idx));
    chk(int'(cur_col) == col_of(e_idx), {tag, " col"}, int'(cur_col), col_of(e_idx));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rep_done = 0; test_done = 0; fault_in = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    e_idx = 0; e_back = 0; e_step = 0;
    for (int i = 0; i < N; i++) last_visit[i] = -1;
  endtask

  // one step; called at the negedge where the replicate phase begins
  task automatic do_step(int dr, int dt, bit flt, bit noise);
    bit e_pass;
    step_start = cyc;
    chk(rep_req == 1'b1 && test_req == 1'b0, "R2 step start rep_req", int'(rep_req), 1);
    chk_pos("R3 position");
    for (int i = 1; i < dr; i++) begin
      if (noise) begin test_done = 1'($urandom % 2); fault_in = 1'($urandom % 2); end
      @(negedge clk);
      test_done = 0; fault_in = 0;
      chk(rep_req == 1'b1 && test_req == 1'b0, "R2 stray test_done ignored", int'(test_req), 0);
      chk_pos("R6 hold in replicate");
    end
    rep_done = 1'b1;
    @(negedge clk);
    rep_done = 1'b0;
    chk(test_req == 1'b1 && rep_req == 1'b0, "R2 test after replicate", int'(test_req), 1);
    for (int i = 1; i < dt; i++) begin
      if (noise) begin rep_done = 1'($urandom % 2); fault_in = 1'($urandom % 2); end
      @(negedge clk);
      rep_done = 0; fault_in = 0;
      chk(test_req == 1'b1 && fault_hit == 1'b0, "R7 fault without done ignored", int'(fault_hit), 0);
      chk_pos("R6 hold in test");
    end
    test_done = 1'b1; fault_in = flt;
    @(negedge clk);
    test_done = 1'b0; fault_in = 1'b0;
    e_step++;
    chk(int'(step_cnt) == e_step, "R5 step count", int'(step_cnt), e_step);
    if (flt) begin
      chk(fault_hit == 1'b1, "R7 fault_hit", int'(fault_hit), 1);
      chk(int'(fault_row) == row_of(e_idx), "R7 fault_row", int'(fault_row), row_of(e_idx));
      chk(int'(fault_col) == col_of(e_idx), "R7 fault_col", int'(fault_col), col_of(e_idx));
      chk(!rep_req && !test_req, "R7 requests low", int'(rep_req), 0);
      chk_pos("R7 position frozen");
    end else begin
      e_pass = 0;
      if (!e_back) begin
        if (e_idx == N - 1) begin e_back = 1; e_idx = N - 2; e_pass = 1; end
        else e_idx++;
      end else begin
        if (e_idx == 0) begin e_back = 0; e_idx = 1; e_pass = 1; end
        else e_idx--;
      end
      chk(pass_done == e_pass, "R4 pass_done", int'(pass_done), int'(e_pass));
      chk(dir_back == e_back, "R4 direction", int'(dir_back), int'(e_back));
      chk_pos("R4 next cell");
    end
  endtask

  initial begin
    int k, iv, max0, min1;
    void'($urandom(32'd4711));
    @(negedge clk);
    chk(int'(cur_row) == 0 && int'(cur_col) == 0, "R1 reset position", int'(cur_row), 0);
    chk(step_cnt == '0 && !dir_back && !fault_hit && !pass_done, "R1 reset status",
        int'(step_cnt), 0);
    do_reset();
    chk(rep_req == 1'b1 && test_req == 1'b0, "R1 rep_req after reset", int'(rep_req), 1);
    chk(int'(cur_row) == 0 && int'(cur_col) == 0 && !dir_back, "R1 origin forward",
        int'(cur_row), 0);

    // random phase lengths with stray strobes, two and a half passes
    for (int s = 0; s < 30; s++)
      do_step(1 + int'($urandom % 4), 1 + int'($urandom % 4), 1'b0, 1'b1);

    // fixed phase lengths: revisit bounds
    do_reset();
    max0 = 0; min1 = 1 << 30;
    for (int s = 0; s < 50; s++) begin
      k = e_idx;
      do_step(3, 2, 1'b0, 1'b0);
      if (last_visit[k] >= 0) begin
        iv = step_start - last_visit[k];
        if (k == 0) begin
          chk(iv == 2 * (N - 1) * 5, "R8 corner revisit", iv, 2 * (N - 1) * 5);
          if (iv > max0) max0 = iv;
        end
        if (k == 1) begin
          chk(iv == 10 || iv == 2 * (N - 2) * 5, "R8 cell1 revisit", iv, 10);
          if (iv < min1) min1 = iv;
        end
      end
      last_visit[k] = step_start;
    end
    chk(max0 == (N - 1) * 2 * 5, "R8 max bound", max0, (N - 1) * 2 * 5);
    chk(min1 == 2 * 5, "R8 min bound", min1, 10);

    // fault halts rotation
    do_step(2, 2, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      rep_done = 1; test_done = 1; fault_in = 1;
      @(negedge clk);
      rep_done = 0; test_done = 0; fault_in = 0;
      chk(!rep_req && !test_req && fault_hit, "R7 halted ignores strobes", int'(rep_req), 0);
      chk(int'(step_cnt) == e_step, "R7 step frozen", int'(step_cnt), e_step);
      chk_pos("R7 halted position");
    end

    do_reset();
    chk(!fault_hit && rep_req && int'(cur_row) == 0 && int'(cur_col) == 0 && !dir_back,
        "R1 reset clears halt", int'(fault_hit), 0);
    chk(step_cnt == '0, "R1 reset step count", int'(step_cnt), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule